// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Qualification

This block is the receive front end of an asynchronous serial port. The receive line passes through a two-flop synchroniser. The block then examines the line once per sample tick, at sixteen ticks per bit period. A falling edge opens a tentative start bit, which is confirmed by a two-of-three vote. Eight or nine data bits are then shifted in, least significant first, followed by one stop bit. Every bit is decided by a three-sample majority taken around the bit centre. When the stop bit is decided, the block presents the received word together with noise, framing-error and break flags, and pulses a one-cycle valid strobe.

Two recovery rules set this receiver apart. After a framing error that is not a break, edge search is held off until the end of the expected stop slot. At that point a logic-1 history is forced, so a line that is still low is taken as the next start edge exactly when that edge is due. After a break, no history is forced. The line must be seen high before a new start edge can count.

The control is a five-state machine:
- **HUNT**: edge search.
- **VERIFY**: start confirmation.
- **DATA**: start-bit tail and data bits.
- **STOP**: stop-bit decision.
- **RESYNC**: hold-off after a plain framing error.

Its transitions are:
- HUNT→VERIFY on a high-to-low edge.
- VERIFY→DATA when the start bit is accepted.
- VERIFY→HUNT when the start bit is rejected.
- DATA→STOP at the end of the last data slot.
- STOP→HUNT on a good stop or on a break.
- STOP→RESYNC on a framing error without a break.
- RESYNC→HUNT at the end of the stop slot.

Top module: `uart_rx_qualifier`

## Requirements
- R1: After reset, `rx_word` is 0 and `rx_valid`, `rx_noise`, `rx_ferr` and `rx_break` are 0. A line held low from reset onward starts no frame until it has been seen high.
- R2: A start edge is a sampled 1 followed by a sampled 0. Taking the edge sample as phase 0, the line is sampled again at phases 3, 5 and 7. The start bit is accepted when at least two of those samples are 0. Otherwise no word is produced and edge search resumes.
- R3: `rx_noise` is delivered with the word. It is 1 when any three-sample vote of that frame (start, any data bit, or stop) was not unanimous.
- R4: Data bits are decided by majority of phases 7, 8 and 9 of each bit slot. Bit 0 of `rx_word` is the first bit received. With `mode9`=1 (read at the start edge) nine bits are received. With `mode9`=0 eight bits are received and `rx_word[8]` is 0.
- R5: `rx_valid` is high for exactly one clock per frame, at the stop decision. `rx_word` and the flags hold their values until the next pulse.
- R6: `rx_ferr` is 1 when the majority of the stop-bit samples is 0.
- R7: `rx_break` is 1 when all data bits and the stop bit decide 0. This is 10 zero bits in 8-bit mode or 11 in 9-bit mode, counting the start bit. It comes with `rx_ferr`=1 and `rx_word`=0. In 9-bit mode, ten zero bits followed by a high stop slot are a plain zero word.
- R8: After a framing error without a break, no edge is taken before the end of the stop slot. The next sample is then treated as following a 1, so a low line there starts a frame exactly one frame period after the previous start.
- R9: After a break, a start edge is recognised only once the line has been sampled high. A line that stays low after a break produces no further words.
- R10: The receiver advances only on clocks with `sample_en`=1. The line may change freely between ticks without effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample tick, 16 per bit period |
| rxd | input | 1 | Asynchronous receive line, idle high |
| mode9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| rx_word | output | 9 | Received word, first bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe when word and flags are updated |
| rx_noise | output | 1 | A vote in the frame was not unanimous |
| rx_ferr | output | 1 | Stop bit decided low |
| rx_break | output | 1 | All-zero frame including stop position |

## Verification
A wrong phase count or slot count shows within one frame as a shifted or wrong word, or as a false framing error at the next `rx_valid`. A wrong sample history after a framing error or a break shows in the following frame period. It appears either as a missing word for back-to-back frames or as extra words while the line stays low. Noise and vote faults surface in the flags delivered with the same frame. The directed cases therefore pair each recovery case with the frame that follows it.

// File: rtl/uartq_pkg.sv
package uartq_pkg;
    typedef enum logic [2:0] {
        S_HUNT,
        S_VERIFY,
        S_DATA,
        S_STOP,
        S_RESYNC
    } rxq_state_e;
endpackage

// File: rtl/uartq_sync.sv
module uartq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uartq_vote.sv
module uartq_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic din,
    output logic maj,
    output logic split
);
    logic [1:0] taps_q;
    logic [2:0] votes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       taps_q <= '0;
        else if (capture) taps_q <= {taps_q[0], din};
    end

    assign votes = {taps_q, din};
    assign maj   = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
    assign split = (|votes) & ~(&votes);
endmodule

// File: rtl/uartq_shift.sv
module uartq_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    input  logic         wide,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;
    logic [W-1:0] nxt;
    int           top;

    assign top = wide ? W - 1 : W - 2;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i == W - 1) begin : g_msb
                assign nxt[i] = wide ? din : 1'b0;
            end else begin : g_low
                assign nxt[i] = (i == top) ? din :
                                (i < top)  ? sr_q[i+1] : 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr_q <= '0;
        else if (clr)   sr_q <= '0;
        else if (shift) sr_q <= nxt;
    end

    assign word = sr_q;
endmodule

// File: rtl/uart_rx_qualifier.sv
module uart_rx_qualifier
    import uartq_pkg::*;
#(
    parameter int OVERSAMPLE   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int WORD_MAX     = 9,
    parameter int VERIFY_FIRST = 3,
    parameter int VERIFY_STEP  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic                rxd,
    input  logic                mode9,
    output logic [WORD_MAX-1:0] rx_word,
    output logic                rx_valid,
    output logic                rx_noise,
    output logic                rx_ferr,
    output logic                rx_break
);
    localparam int PHASE_W = $clog2(OVERSAMPLE);
    localparam int SLOT_W  = $clog2(WORD_MAX + 2);
    localparam logic [PHASE_W-1:0] PH_V1   = PHASE_W'(VERIFY_FIRST);
    localparam logic [PHASE_W-1:0] PH_V2   = PHASE_W'(VERIFY_FIRST + VERIFY_STEP);
    localparam logic [PHASE_W-1:0] PH_V3   = PHASE_W'(VERIFY_FIRST + 2 * VERIFY_STEP);
    localparam logic [PHASE_W-1:0] PH_C1   = PHASE_W'(OVERSAMPLE / 2 - 1);
    localparam logic [PHASE_W-1:0] PH_C2   = PHASE_W'(OVERSAMPLE / 2);
    localparam logic [PHASE_W-1:0] PH_C3   = PHASE_W'(OVERSAMPLE / 2 + 1);
    localparam logic [PHASE_W-1:0] PH_LAST = PHASE_W'(OVERSAMPLE - 1);
    localparam logic [SLOT_W-1:0]  SLOT_WIDE   = SLOT_W'(WORD_MAX);
    localparam logic [SLOT_W-1:0]  SLOT_NARROW = SLOT_W'(WORD_MAX - 1);

    rxq_state_e          state_q, state_d;
    logic                line;
    logic [PHASE_W-1:0]  phase_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                hist_q;
    logic                noise_q;
    logic                zero_q;
    logic                wide_q;
    logic                vote_maj, vote_split;
    logic [WORD_MAX-1:0] shift_word;

    logic edge_hit, v_cap, start_dec, start_ok, bit_dec, stop_dec;
    logic slot_end, last_slot, frame_break;

    // ---------------- submodules ----------------
    uartq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line)
    );

    uartq_vote u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(v_cap),
        .din    (line),
        .maj    (vote_maj),
        .split  (vote_split)
    );

    uartq_shift #(.W(WORD_MAX)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (edge_hit),
        .shift(bit_dec),
        .din  (vote_maj),
        .wide (wide_q),
        .word (shift_word)
    );

    // ---------------- decode of tick events ----------------
    assign edge_hit  = sample_en && (state_q == S_HUNT) && hist_q && !line;
    assign v_cap     = sample_en &&
                       (((state_q == S_VERIFY) && ((phase_q == PH_V1) || (phase_q == PH_V2))) ||
                        (((state_q == S_DATA) || (state_q == S_STOP)) &&
                         ((phase_q == PH_C1) || (phase_q == PH_C2))));
    assign start_dec = sample_en && (state_q == S_VERIFY) && (phase_q == PH_V3);
    assign start_ok  = start_dec && !vote_maj;
    assign bit_dec   = sample_en && (state_q == S_DATA) && (phase_q == PH_C3) && (slot_q != '0);
    assign stop_dec  = sample_en && (state_q == S_STOP) && (phase_q == PH_C3);
    assign slot_end  = sample_en && (phase_q == PH_LAST);
    assign last_slot = (slot_q == (wide_q ? SLOT_WIDE : SLOT_NARROW));
    assign frame_break = !vote_maj && zero_q;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: begin
                if (edge_hit) state_d = S_VERIFY;
            end
            S_VERIFY: begin
                if (start_dec) state_d = vote_maj ? S_HUNT : S_DATA;
            end
            S_DATA: begin
                if (slot_end && last_slot) state_d = S_STOP;
            end
            S_STOP: begin
                if (stop_dec) begin
                    if (vote_maj || frame_break) state_d = S_HUNT;
                    else                         state_d = S_RESYNC;
                end
            end
            S_RESYNC: begin
                if (slot_end) state_d = S_HUNT;
            end
            default: state_d = S_HUNT;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // ---------------- phase, slot and frame bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            slot_q  <= '0;
        end else if (sample_en) begin
            if (state_q == S_HUNT)      phase_q <= edge_hit ? PHASE_W'(1) : '0;
            else if (phase_q == PH_LAST) phase_q <= '0;
            else                         phase_q <= phase_q + 1'b1;

            if (start_ok)                         slot_q <= '0;
            else if ((state_q == S_DATA) && slot_end) slot_q <= slot_q + 1'b1;
        end
    end

    // Sample history: last level seen by edge search (forced after recovery)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else if (sample_en) begin
            unique case (state_q)
                S_HUNT:   hist_q <= line;
                S_VERIFY: if (start_dec && vote_maj) hist_q <= line;
                S_STOP:   if (stop_dec) hist_q <= vote_maj;
                S_RESYNC: if (slot_end) hist_q <= 1'b1;
                default:  hist_q <= hist_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            noise_q <= 1'b0;
            zero_q  <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            if (edge_hit) begin
                noise_q <= 1'b0;
                zero_q  <= 1'b1;
                wide_q  <= mode9;
            end else begin
                if (start_ok || bit_dec) noise_q <= noise_q | vote_split;
                if (bit_dec && vote_maj) zero_q <= 1'b0;
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word  <= '0;
            rx_valid <= 1'b0;
            rx_noise <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_break <= 1'b0;
        end else begin
            rx_valid <= stop_dec;
            if (stop_dec) begin
                rx_word  <= shift_word;
                rx_noise <= noise_q | vote_split;
                rx_ferr  <= !vote_maj;
                rx_break <= frame_break;
            end
        end
    end
endmodule

// File: rtl/uartq_checks.sv
module uartq_checks
    import uartq_pkg::*;
#(
    parameter int WORD_MAX = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_en,
    input rxq_state_e          state_q,
    input logic                hist_q,
    input logic                wide_q,
    input logic [WORD_MAX-1:0] rx_word,
    input logic                rx_valid,
    input logic                rx_ferr,
    input logic                rx_break
);
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    p_break_is_ferr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_ferr && (rx_word == '0)));

    p_narrow_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !wide_q) |-> !rx_word[WORD_MAX-1]);

    p_no_tick_no_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(state_q));

    p_hunt_needs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_HUNT) && !hist_q) |=> (state_q == S_HUNT));

    p_resync_forces_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_HUNT) && ($past(state_q) == S_RESYNC)) |-> hist_q);
endmodule

bind uart_rx_qualifier uartq_checks #(.WORD_MAX(WORD_MAX)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .state_q  (state_q),
    .hist_q   (hist_q),
    .wide_q   (wide_q),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr),
    .rx_break (rx_break)
);

// File: tb/uart_rx_qualifier_tb_top.sv
module uart_rx_qualifier_tb_top;
    logic       clk, rst_n, sample_en, rxd, mode9, hold;
    logic [8:0] rx_word;
    logic       rx_valid, rx_noise, rx_ferr, rx_break;
    int         total, bad, cap_cnt, tdiv;
    logic [8:0] cap_word;
    logic       cap_noise, cap_ferr, cap_brk, last_v;

    uart_rx_qualifier dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd), .mode9(mode9),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_noise(rx_noise),
        .rx_ferr(rx_ferr), .rx_break(rx_break)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    // sample tick every fourth clock, suppressed while hold is set
    initial begin
        sample_en = 1'b0;
        tdiv = 0;
        forever begin
            @(negedge clk);
            tdiv = (tdiv + 1) % 4;
            sample_en = (tdiv == 3) && !hold;
        end
    end

    // capture of every delivered word
    initial begin
        cap_cnt = 0;
        cap_word = '0; cap_noise = 0; cap_ferr = 0; cap_brk = 0;
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                cap_cnt++;
                cap_word = rx_word; cap_noise = rx_noise;
                cap_ferr = rx_ferr; cap_brk = rx_break;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // value v is seen by exactly the next sample tick
    task automatic put(input logic v);
        @(posedge clk);
        while (!sample_en) @(posedge clk);
        @(negedge clk);
        rxd = v;
        last_v = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b1);
    endtask

    task automatic tick_gap();
        #1 hold = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            rxd = ~rxd;
        end
        rxd = last_v;
        repeat (4) @(negedge clk);
        #1 hold = 1'b0;
    endtask

    task automatic send_frame(input logic [8:0] data, input logic nine, input logic stop_v,
                              input logic [15:0] sflip, input logic [15:0] d0flip,
                              input int gap_slot);
        int   nb;
        logic bv, v;
        nb = nine ? 9 : 8;
        mode9 = nine;
        for (int sl = 0; sl < nb + 2; sl++) begin
            if (sl == 0)           bv = 1'b0;
            else if (sl == nb + 1) bv = stop_v;
            else                   bv = data[sl-1];
            for (int s = 0; s < 16; s++) begin
                v = bv;
                if (sl == 0 && sflip[s])  v = ~v;
                if (sl == 1 && d0flip[s]) v = ~v;
                put(v);
            end
            if (sl == gap_slot) tick_gap();
        end
    endtask

    task automatic frame_chk(input string req, input int c0, input int n,
                             input logic [8:0] w, input logic nz,
                             input logic fe, input logic bk);
        chk(req, "word count", 16'(cap_cnt - c0), 16'(n));
        chk(req, "word", {7'd0, cap_word}, {7'd0, w});
        chk(req, "noise", {15'd0, cap_noise}, {15'd0, nz});
        chk(req, "ferr", {15'd0, cap_ferr}, {15'd0, fe});
        chk(req, "break", {15'd0, cap_brk}, {15'd0, bk});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_low_line();
        int c0;
        chk("R1", "reset word", {7'd0, rx_word}, 16'd0);
        chk("R1", "reset valid", {15'd0, rx_valid}, 16'd0);
        chk("R1", "reset flags", {13'd0, rx_noise, rx_ferr, rx_break}, 16'd0);
        c0 = cap_cnt;
        for (int i = 0; i < 200; i++) put(1'b0);
        chk("R1", "low line after reset gives no word", 16'(cap_cnt - c0), 16'd0);
        idle(20);
    endtask

    task automatic t_clean();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h0A5, 1'b0, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R4 clean 8-bit", c0, 1, 9'h0A5, 0, 0, 0);
        c0 = cap_cnt;
        send_frame(9'h1C3, 1'b1, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R4 clean 9-bit", c0, 1, 9'h1C3, 0, 0, 0);
        c0 = cap_cnt;
        send_frame(9'h1FF, 1'b0, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R4 8-bit msb zero", c0, 1, 9'h0FF, 0, 0, 0);
    endtask

    task automatic t_hold();
        idle(40);
        chk("R5", "word held", {7'd0, rx_word}, 16'h0FF);
        chk("R5", "valid low between frames", {15'd0, rx_valid}, 16'd0);
    endtask

    task automatic t_start_noise();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h03C, 1'b0, 1'b1, 16'h0020, 16'h0, -1); idle(4);
        frame_chk("R3 R2 one noisy start sample", c0, 1, 9'h03C, 1, 0, 0);
    endtask

    task automatic t_start_reject();
        int c0;
        c0 = cap_cnt;
        put(1'b0); put(1'b0);
        idle(60);
        chk("R2", "short glitch rejected", 16'(cap_cnt - c0), 16'd0);
        send_frame(9'h05A, 1'b0, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R2 frame after reject", c0, 1, 9'h05A, 0, 0, 0);
    endtask

    task automatic t_data_noise();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h0C7, 1'b0, 1'b1, 16'h0, 16'h0100, -1); idle(4);
        frame_chk("R3 noisy data sample", c0, 1, 9'h0C7, 1, 0, 0);
    endtask

    task automatic t_ferr();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h055, 1'b0, 1'b0, 16'h0, 16'h0, -1); idle(20);
        frame_chk("R6 stop low 8-bit", c0, 1, 9'h055, 0, 1, 0);
        c0 = cap_cnt;
        send_frame(9'h100, 1'b1, 1'b0, 16'h0, 16'h0, -1); idle(20);
        frame_chk("R6 R7 stop low 9-bit not break", c0, 1, 9'h100, 0, 1, 0);
    endtask

    task automatic t_back_to_back();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h081, 1'b0, 1'b0, 16'h0, 16'h0, -1);
        frame_chk("R8 first frame ferr", c0, 1, 9'h081, 0, 1, 0);
        send_frame(9'h04E, 1'b0, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R8 artificial edge next frame", c0, 2, 9'h04E, 0, 0, 0);
    endtask

    task automatic t_break8();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h000, 1'b0, 1'b0, 16'h0, 16'h0, -1);
        frame_chk("R7 break 8-bit", c0, 1, 9'h000, 0, 1, 1);
        for (int i = 0; i < 48; i++) put(1'b0);
        idle(20);
        chk("R9", "no word while low after break", 16'(cap_cnt - c0), 16'd1);
        send_frame(9'h096, 1'b0, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R9 frame after break", c0, 2, 9'h096, 0, 0, 0);
    endtask

    task automatic t_break9();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h000, 1'b1, 1'b0, 16'h0, 16'h0, -1); idle(20);
        frame_chk("R7 break 9-bit", c0, 1, 9'h000, 0, 1, 1);
        c0 = cap_cnt;
        send_frame(9'h000, 1'b1, 1'b1, 16'h0, 16'h0, -1); idle(4);
        frame_chk("R7 ten zeros in 9-bit is a word", c0, 1, 9'h000, 0, 0, 0);
    endtask

    task automatic t_tick_gap();
        int c0;
        c0 = cap_cnt;
        send_frame(9'h06A, 1'b0, 1'b1, 16'h0, 16'h0, 3); idle(4);
        frame_chk("R10 line toggles between ticks", c0, 1, 9'h06A, 0, 0, 0);
    endtask

    initial begin
        total = 0; bad = 0;
        rxd = 1'b0; mode9 = 1'b0; hold = 1'b0; last_v = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_low_line();
        t_clean();
        t_hold();
        t_start_noise();
        t_start_reject();
        t_data_noise();
        t_ferr();
        t_back_to_back();
        t_break8();
        t_break9();
        t_tick_gap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule